// File: doc/BRIEF.md
# SPI Bit-Slip Realigner

This block sits between a byte-wide SPI shift register and the logic that uses the bytes. A serial link can lose or gain clock edges. When that happens every received byte is offset by the same number of bits, and the offset lasts until something corrects it. The block watches the raw byte stream and finds the offset by rebuilding each byte at every possible offset. An offset is accepted when its rebuilt stream shows an all-ones guide byte directly followed by a start marker. Once locked, it delivers realigned bytes one clock after each raw byte arrives.

The far end of the link sees the same slip. So the block also shifts every outgoing byte by the locked offset. It keeps the leftover bits of the previous outgoing byte in a register, so that the transmitted bit stream stays continuous from one byte to the next.

A frame consists of `GUIDES` guide bytes of all ones, followed by `PAYLOAD` payload bytes. The first payload byte is the marker. The block counts positions within the frame while locked and pulses status at frame start and frame end. It checks the marker at its expected position in every frame. A missing marker drops the lock, and the search starts again.

Top module: `slip_realigner`

## Requirements
- R1: After reset, `locked` is 0, `offset` is 0 and `aligned_valid`, `frame_start` and `frame_done` are 0. `aligned_valid` stays 0 for every raw byte received while unlocked, except for the byte that achieves lock.
- R2: Bits are handled most significant first. The byte rebuilt at offset N (1 to W-1) is {previous raw byte[N-1:0], current raw byte[W-1:N]}. At offset 0 it is the current raw byte. With W=8 and N=1, raw 0x52 following a raw byte whose bit 0 is 1 rebuilds to 0xA9, and raw 0x6C following 0x52 rebuilds to 0x36.
- R3: While unlocked, the block locks on a raw byte when, at some offset N, the rebuilt byte of the previous raw byte equals `GUIDE` (default all ones) and the rebuilt current byte equals `MARKER` (default 0xA9). If several offsets qualify, the lowest one wins. `offset` then reads N.
- R4: The locking byte is output as `MARKER`. Every later raw byte received while locked produces exactly one `aligned_valid` pulse, in the clock cycle after its `rx_valid`, carrying the byte rebuilt at the locked offset. No pulse occurs in a cycle without a preceding `rx_valid`.
- R5: Frame positions run from 0 to GUIDES+PAYLOAD-1, and the marker sits at position GUIDES. `frame_start` pulses together with the output of the marker byte. `frame_done` pulses together with the output of the byte at position GUIDES+PAYLOAD-1, which is the PAYLOAD-th payload byte, counting the marker as the first.
- R6: When locked, if the rebuilt byte at frame position GUIDES differs from `MARKER`, that byte is not output, `locked` falls to 0 and `offset` returns to 0. The search then restarts and can lock at the next valid guide/marker boundary.
- R7: `tx_byte_out` = {residual[N-1:0], tx_byte_in[W-1:N]} combinationally, where N is `offset` and residual is the last byte loaded with `tx_load` (0 after reset). At offset 0, `tx_byte_out` equals `tx_byte_in`.
- R8: A synchronous `resync` pulse clears `locked`, `offset`, the frame position and the guide history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resync | input | 1 | Synchronous lock clear |
| rx_valid | input | 1 | Raw received byte strobe |
| rx_byte | input | W | Raw received byte |
| tx_load | input | 1 | Outgoing byte accepted; updates residual |
| tx_byte_in | input | W | Outgoing byte before shifting |
| tx_byte_out | output | W | Outgoing byte shifted by the locked offset |
| aligned_valid | output | 1 | Realigned byte strobe |
| aligned_byte | output | W | Realigned byte |
| locked | output | 1 | Offset found and in force |
| offset | output | $clog2(W) | Locked bit offset |
| frame_start | output | 1 | Marker byte being output |
| frame_done | output | 1 | Last payload byte being output |

## Verification
The bench builds the block with W=8, GUIDES=4, PAYLOAD=8 and the default marker 0xA9. The short 12-byte frame lets a sweep over all eight offsets run three frames each. Each sweep covers acquisition, continuous locked output, frame-start and frame-end pulses, and the drop and reacquisition caused by a deliberately corrupted marker. The slipped raw stream is computed arithmetically from a known true byte sequence. At offset 1 the raw stream reproduces the 0x52/0x6C example. The transmit shift is checked at every offset against a 16-bit shift of the residual and the new byte.

// File: rtl/slip_pkg.sv
package slip_pkg;
   localparam int SLIP_DEF_W       = 8;
   localparam int SLIP_DEF_GUIDES  = 4;
   localparam int SLIP_DEF_PAYLOAD = 128;

   function automatic int slip_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/slip_join.sv
module slip_join
   import slip_pkg::*;
#(
   parameter int W = SLIP_DEF_W
) (
   input  logic [W-2:0]          prev_tail,
   input  logic [W-1:0]          cur,
   output logic [W-1:0][W-1:0]   opts
);
   for (genvar k = 0; k < W; k++) begin : g_off
      if (k == 0) begin : g_pass
         assign opts[k] = cur;
      end else begin : g_join
         assign opts[k] = {prev_tail[k-1:0], cur[W-1:k]};
      end
   end
endmodule

// File: rtl/slip_lock.sv
module slip_lock
   import slip_pkg::*;
#(
   parameter int             W       = SLIP_DEF_W,
   parameter int             GUIDES  = SLIP_DEF_GUIDES,
   parameter int             PAYLOAD = SLIP_DEF_PAYLOAD,
   parameter logic [W-1:0]   GUIDE   = '1,
   parameter logic [W-1:0]   MARKER  = W'('hA9),
   parameter int             OFF_W   = slip_bits(W)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  resync,
   input  logic                  rx_valid,
   input  logic [W-1:0][W-1:0]   opts,
   output logic                  locked,
   output logic [OFF_W-1:0]      offset,
   output logic                  aligned_valid,
   output logic [W-1:0]          aligned_byte,
   output logic                  frame_start,
   output logic                  frame_done
);
   localparam int FRAME = GUIDES + PAYLOAD;
   localparam int IDX_W = slip_bits(FRAME);
   localparam logic [IDX_W-1:0] MARK_POS  = IDX_W'(GUIDES);
   localparam logic [IDX_W-1:0] AFTER_MK  = IDX_W'(GUIDES + 1);
   localparam logic [IDX_W-1:0] LAST_POS  = IDX_W'(FRAME - 1);

   logic [W-1:0]     guide_now, guide_seen, mark_now, hit;
   logic             found;
   logic [OFF_W-1:0] pick;
   logic [IDX_W-1:0] pos;
   logic [W-1:0]     sel;

   always_comb begin
      for (int k = 0; k < W; k++) begin
         guide_now[k] = (opts[k] == GUIDE);
         mark_now[k]  = (opts[k] == MARKER);
      end
   end

   assign hit = guide_seen & mark_now;
   assign sel = opts[offset];

   // lowest qualifying offset wins
   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int k = W - 1; k >= 0; k--) begin
         if (hit[k]) begin
            found = 1'b1;
            pick  = OFF_W'(k);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked        <= 1'b0;
         offset        <= '0;
         pos           <= '0;
         guide_seen    <= '0;
         aligned_valid <= 1'b0;
         aligned_byte  <= '0;
         frame_start   <= 1'b0;
         frame_done    <= 1'b0;
      end else if (resync) begin
         locked        <= 1'b0;
         offset        <= '0;
         pos           <= '0;
         guide_seen    <= '0;
         aligned_valid <= 1'b0;
         frame_start   <= 1'b0;
         frame_done    <= 1'b0;
      end else begin
         aligned_valid <= 1'b0;
         frame_start   <= 1'b0;
         frame_done    <= 1'b0;
         if (rx_valid) begin
            guide_seen <= guide_now;
            if (!locked) begin
               if (found) begin
                  locked        <= 1'b1;
                  offset        <= pick;
                  pos           <= AFTER_MK;
                  aligned_valid <= 1'b1;
                  aligned_byte  <= MARKER;
                  frame_start   <= 1'b1;
               end
            end else if (pos == MARK_POS && sel != MARKER) begin
               locked <= 1'b0;
               offset <= '0;
               pos    <= '0;
            end else begin
               aligned_valid <= 1'b1;
               aligned_byte  <= sel;
               frame_start   <= (pos == MARK_POS);
               frame_done    <= (pos == LAST_POS);
               pos           <= (pos == LAST_POS) ? '0 : pos + 1'b1;
            end
         end
      end
   end

   // R4
   valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aligned_valid |-> locked);
   // R4
   valid_follows_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rx_valid) |-> !aligned_valid);
   // R3
   lock_rise_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> frame_start);
   // R5
   start_is_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (aligned_valid && aligned_byte == MARKER));
   // R5
   done_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (aligned_valid && !frame_start));
   // R6
   unlocked_zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> (offset == '0));
endmodule

// File: rtl/slip_tx.sv
module slip_tx
   import slip_pkg::*;
#(
   parameter int W     = SLIP_DEF_W,
   parameter int OFF_W = slip_bits(W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_load,
   input  logic [W-1:0]     tx_byte_in,
   input  logic [OFF_W-1:0] offset,
   output logic [W-1:0]     tx_byte_out
);
   logic [W-2:0]        residual;
   logic [W-1:0][W-1:0] tx_opts;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       residual <= '0;
      else if (tx_load) residual <= tx_byte_in[W-2:0];
   end

   slip_join #(.W(W)) u_tx_join (
      .prev_tail (residual),
      .cur       (tx_byte_in),
      .opts      (tx_opts)
   );

   assign tx_byte_out = tx_opts[offset];

   // R7
   tx_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (offset == '0) |-> (tx_byte_out == tx_byte_in));
endmodule

// File: rtl/slip_realigner.sv
module slip_realigner
   import slip_pkg::*;
#(
   parameter int             W       = SLIP_DEF_W,
   parameter int             GUIDES  = SLIP_DEF_GUIDES,
   parameter int             PAYLOAD = SLIP_DEF_PAYLOAD,
   parameter logic [W-1:0]   GUIDE   = '1,
   parameter logic [W-1:0]   MARKER  = W'('hA9),
   localparam int            OFF_W   = slip_bits(W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             resync,
   input  logic             rx_valid,
   input  logic [W-1:0]     rx_byte,
   input  logic             tx_load,
   input  logic [W-1:0]     tx_byte_in,
   output logic [W-1:0]     tx_byte_out,
   output logic             aligned_valid,
   output logic [W-1:0]     aligned_byte,
   output logic             locked,
   output logic [OFF_W-1:0] offset,
   output logic             frame_start,
   output logic             frame_done
);
   if (W < 2) begin : g_bad_w
      $error("slip_realigner: W must be at least 2");
   end
   if ((1 << OFF_W) != W) begin : g_bad_pow
      $error("slip_realigner: W must be a power of two");
   end
   if (GUIDES < 1) begin : g_bad_guides
      $error("slip_realigner: GUIDES must be at least 1");
   end
   if (PAYLOAD < 2) begin : g_bad_payload
      $error("slip_realigner: PAYLOAD must be at least 2");
   end
   if (MARKER == GUIDE) begin : g_bad_marker
      $error("slip_realigner: MARKER must differ from GUIDE");
   end

   logic [W-2:0]        prev_tail;
   logic [W-1:0][W-1:0] rx_opts;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        prev_tail <= '0;
      else if (rx_valid) prev_tail <= rx_byte[W-2:0];
   end

   slip_join #(.W(W)) u_rx_join (
      .prev_tail (prev_tail),
      .cur       (rx_byte),
      .opts      (rx_opts)
   );

   slip_lock #(
      .W(W), .GUIDES(GUIDES), .PAYLOAD(PAYLOAD),
      .GUIDE(GUIDE), .MARKER(MARKER), .OFF_W(OFF_W)
   ) u_lock (
      .clk           (clk),
      .rst_n         (rst_n),
      .resync        (resync),
      .rx_valid      (rx_valid),
      .opts          (rx_opts),
      .locked        (locked),
      .offset        (offset),
      .aligned_valid (aligned_valid),
      .aligned_byte  (aligned_byte),
      .frame_start   (frame_start),
      .frame_done    (frame_done)
   );

   slip_tx #(.W(W), .OFF_W(OFF_W)) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .tx_load     (tx_load),
      .tx_byte_in  (tx_byte_in),
      .offset      (offset),
      .tx_byte_out (tx_byte_out)
   );
endmodule

// File: tb/tb_slip_realigner.sv
module tb_slip_realigner;
   localparam int G    = 4;
   localparam int P    = 8;
   localparam int FR   = G + P;
   localparam int NF   = 3;
   localparam int LEAD = 3;
   localparam int LEN  = LEAD + NF * FR;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       resync = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       tx_load = 1'b0;
   logic [7:0] tx_byte_in = '0;
   logic [7:0] tx_byte_out;
   logic       aligned_valid;
   logic [7:0] aligned_byte;
   logic       locked;
   logic [2:0] offset;
   logic       frame_start;
   logic       frame_done;

   int vectors = 0;
   int errors  = 0;
   logic [7:0] t [0:LEN];
   logic [7:0] res_model = '0;

   always #4 clk = ~clk;

   slip_realigner #(.W(8), .GUIDES(G), .PAYLOAD(P)) dut (
      .clk(clk), .rst_n(rst_n), .resync(resync),
      .rx_valid(rx_valid), .rx_byte(rx_byte),
      .tx_load(tx_load), .tx_byte_in(tx_byte_in), .tx_byte_out(tx_byte_out),
      .aligned_valid(aligned_valid), .aligned_byte(aligned_byte),
      .locked(locked), .offset(offset),
      .frame_start(frame_start), .frame_done(frame_done)
   );

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] raw_at(input int i, input int n);
      logic [15:0] w;
      w = {t[i], t[i+1]};
      return 8'(w >> (8 - n));
   endfunction

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      chk("R4 idle cycle no strobe", int'(aligned_valid), 0);
      rx_valid = 1'b1;
      rx_byte  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic build(input int n);
      for (int i = 0; i < LEAD; i++) t[i] = 8'h00;
      for (int f = 0; f < NF; f++) begin
         for (int j = 0; j < FR; j++) begin
            int b;
            if (j < G)            b = 8'hFF;
            else if (j == G)      b = (f == 1) ? 8'h00 : 8'hA9;
            else if (j == G + 1)  b = 8'h36;
            else                  b = ((j - G) * 23 + n * 5 + 3) & 8'h7F;
            t[LEAD + f * FR + j] = 8'(b);
         end
      end
      t[LEN] = 8'h00;
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      tx_byte_in = 8'h5C;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset locked", int'(locked), 0);
      chk("R1 reset offset", int'(offset), 0);
      chk("R1 reset aligned_valid", int'(aligned_valid), 0);
      chk("R1 reset frame_start", int'(frame_start), 0);
      chk("R1 reset frame_done", int'(frame_done), 0);
      chk("R7 reset tx passthrough", int'(tx_byte_out), 8'h5C);

      for (int n = 0; n < 8; n++) begin
         bit elock;
         build(n);
         @(negedge clk);
         resync = 1'b1;
         @(negedge clk);
         resync = 1'b0;
         chk("R8 resync locked", int'(locked), 0);
         chk("R8 resync offset", int'(offset), 0);
         elock = 1'b0;
         for (int i = 0; i < LEN; i++) begin
            int  pos, f;
            bit  ismark, corrupt;
            string dtag;
            pos = (i >= LEAD) ? (i - LEAD) % FR : -1;
            f   = (i >= LEAD) ? (i - LEAD) / FR : -1;
            ismark  = (pos == G);
            corrupt = ismark && (f == 1);
            dtag = (n == 1 && (pos == G || pos == G + 1)) ? "R2 realigned byte" : "R4 realigned byte";
            send(raw_at(i, n));
            if (!elock) begin
               if (ismark && !corrupt) begin
                  elock = 1'b1;
                  chk("R3 lock strobe", int'(aligned_valid), 1);
                  chk(dtag, int'(aligned_byte), int'(t[i]));
                  chk("R5 frame_start at lock", int'(frame_start), 1);
               end else begin
                  chk("R1 no strobe while unlocked", int'(aligned_valid), 0);
               end
            end else if (corrupt) begin
               elock = 1'b0;
               chk("R6 bad marker not output", int'(aligned_valid), 0);
            end else begin
               chk("R4 locked strobe", int'(aligned_valid), 1);
               chk(dtag, int'(aligned_byte), int'(t[i]));
               chk("R5 frame_start", int'(frame_start), int'(ismark));
               chk("R5 frame_done", int'(frame_done), int'(pos == FR - 1));
            end
            chk(elock ? "R3 locked flag" : "R6 locked flag", int'(locked), int'(elock));
            chk(elock ? "R3 offset" : "R6 offset", int'(offset), elock ? n : 0);
         end

         for (int q = 0; q < 6; q++) begin
            logic [7:0]  d;
            logic [15:0] w;
            d = 8'((q * 53 + n * 17 + 8'h9C) & 8'hFF);
            @(negedge clk);
            tx_byte_in = d;
            #1;
            w = {res_model, d};
            chk("R7 tx shift", int'(tx_byte_out), int'(8'(w >> n)));
            tx_load = 1'b1;
            @(negedge clk);
            tx_load = 1'b0;
            res_model = d;
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule